// File: doc/BRIEF.md
# Saturating Add/Subtract Unit

This block adds or subtracts two narrow operands and, when the true answer does not fit the output width, pins the result at the nearest limit. It does not wrap around. One input chooses whether the operands are read as unsigned numbers or as two's-complement numbers. Each operand is first widened to a much wider internal width: by filling with zeros when the operands are unsigned, or by copying the top bit when they are signed. The operation is done at that width. The wide answer is then compared with the ceiling and floor of the chosen number range and narrowed back to the operand width.

An operation is presented with a one-cycle valid strobe. One clock later the clamped result appears, together with two flags that say whether the result was pinned at the ceiling or at the floor. With the default width of 8 bits, the unsigned range is 0 to 255 and the signed range is -128 to 127. For example, unsigned 224 + 64 gives 255 with the ceiling flag set, where a wrapping adder would give 32.

Top module: `sat_addsub`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `outValid`, `result`, `ovf` and `unf` all at 0.
- R2: `outValid` is high in exactly the cycle after a clock edge that samples `inValid` high, and low after an edge that samples it low.
- R3: With `signedMode`=0 and `opSub`=0, a sum above 255 gives `result`=255 (0xFF) with `ovf`=1 and `unf`=0.
- R4: With `signedMode`=0 and `opSub`=1, a difference `opA`-`opB` below 0 gives `result`=0 with `unf`=1 and `ovf`=0.
- R5: With `signedMode`=1, a true sum or difference above 127 gives `result`=0x7F with `ovf`=1.
- R6: With `signedMode`=1, a true sum or difference below -128 gives `result`=0x80 with `unf`=1.
- R7: A true result inside the chosen range appears unchanged in `result`, taken as its low 8 bits, with both flags at 0.
- R8: `ovf` and `unf` are never high together.
- R9: After a clock edge that samples `inValid` low, `result`, `ovf` and `unf` keep their previous values, whatever the operand and mode inputs do.
- R10: Operand encoding. `opSub`=1 computes `opA` minus `opB` and `opSub`=0 computes `opA` plus `opB`. `signedMode`=1 reads both operands as two's complement; `signedMode`=0 reads them as unsigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Strobe: operands and controls are valid this cycle |
| opSub | input | 1 | 1 = subtract, 0 = add |
| signedMode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| opA | input | DATA_W | First operand |
| opB | input | DATA_W | Second operand |
| outValid | output | 1 | Result is valid this cycle |
| result | output | DATA_W | Clamped result |
| ovf | output | 1 | Result was pinned at the ceiling |
| unf | output | 1 | Result was pinned at the floor |

## Verification
The hardest cases to reach are the ones right at a limit. A true result of exactly 127 or -128 in signed mode, or exactly 255 or 0 in unsigned mode, must pass through with no flag, while a result one step past the limit must clamp. These cases are few, and they differ between the two modes. The stimulus reaches them by sweeping every first operand against a spread of second operands that includes 0, 127, 128 and 255, in all four mode combinations, with one operation per clock. Directed cases then drive the signed -100 - 100 case and the exact-limit sums. A separate phase idles the strobe while the operands and modes change, to check that the held result does not move.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef struct packed {
    logic load;
    logic clear;
  } satStrobe_t;
endpackage

// File: rtl/sat_widen.sv
module sat_widen #(
  parameter int DATA_W = 8,
  parameter int WIDE_W = 32
) (
  input  logic [DATA_W-1:0] narrowIn,
  input  logic              signedMode,
  output logic [WIDE_W-1:0] wideOut
);
  localparam int PAD_W = WIDE_W - DATA_W;

  logic fillBit;

  // Zero fill for unsigned operands, sign-bit copy for signed operands.
  assign fillBit = signedMode & narrowIn[DATA_W-1];
  assign wideOut = {{PAD_W{fillBit}}, narrowIn};
endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output satStrobe_t strobes,
  output logic       outValid
);
  always_comb begin
    strobes.clear = rst;
    strobes.load  = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid); // R2
  AST_VALID_ONLY: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid); // R2
endmodule

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WIDE_W = 32
) (
  input  logic              clk,
  input  satStrobe_t        strobes,
  input  logic              opSub,
  input  logic              signedMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              ovf,
  output logic              unf
);
  localparam int PAD_W = WIDE_W - DATA_W;
  localparam logic signed [WIDE_W-1:0] U_CEIL  = {{PAD_W{1'b0}}, {DATA_W{1'b1}}};
  localparam logic signed [WIDE_W-1:0] U_FLOOR = '0;
  localparam logic signed [WIDE_W-1:0] S_CEIL  = {{(PAD_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [WIDE_W-1:0] S_FLOOR = {{(PAD_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic [DATA_W-1:0] narrowOps [2];
  logic [WIDE_W-1:0] wideOps   [2];

  assign narrowOps[0] = opA;
  assign narrowOps[1] = opB;

  for (genvar g = 0; g < 2; g++) begin : gWiden
    sat_widen #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_widen (
      .narrowIn  (narrowOps[g]),
      .signedMode(signedMode),
      .wideOut   (wideOps[g])
    );
  end

  logic signed [WIDE_W-1:0] wideRes, ceilW, floorW;
  logic                     aboveCeil, belowFloor;
  logic [DATA_W-1:0]        nextRes;

  always_comb begin
    wideRes    = opSub ? $signed(wideOps[0] - wideOps[1])
                       : $signed(wideOps[0] + wideOps[1]);
    ceilW      = signedMode ? S_CEIL  : U_CEIL;
    floorW     = signedMode ? S_FLOOR : U_FLOOR;
    aboveCeil  = wideRes > ceilW;
    belowFloor = wideRes < floorW;
    if (aboveCeil)       nextRes = ceilW[DATA_W-1:0];
    else if (belowFloor) nextRes = floorW[DATA_W-1:0];
    else                 nextRes = wideRes[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      result <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else if (strobes.load) begin
      result <= nextRes;
      ovf    <= aboveCeil;
      unf    <= belowFloor;
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (strobes.clear)
    !(ovf && unf)); // R8
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub
  import sat_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int WIDE_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              opSub,
  input  logic              signedMode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              ovf,
  output logic              unf
);
  satStrobe_t strobes;

  sat_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  sat_datapath #(.DATA_W(DATA_W), .WIDE_W(WIDE_W)) u_dp (
    .clk       (clk),
    .strobes   (strobes),
    .opSub     (opSub),
    .signedMode(signedMode),
    .opA       (opA),
    .opB       (opB),
    .result    (result),
    .ovf       (ovf),
    .unf       (unf)
  );

  AST_UNSIGNED_CEIL: assert property (@(posedge clk) disable iff (rst)
    (outValid && ovf && !$past(signedMode)) |-> result == {DATA_W{1'b1}}); // R3
  AST_UNSIGNED_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (outValid && unf && !$past(signedMode)) |-> result == '0); // R4
  AST_SIGNED_CEIL: assert property (@(posedge clk) disable iff (rst)
    (outValid && ovf && $past(signedMode)) |-> result == {1'b0, {(DATA_W-1){1'b1}}}); // R5
  AST_SIGNED_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (outValid && unf && $past(signedMode)) |-> result == {1'b1, {(DATA_W-1){1'b0}}}); // R6
  AST_NO_UNF_ON_UADD: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(!signedMode && !opSub)) |-> !unf); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(result) && $stable(ovf) && $stable(unf))); // R9
endmodule

// File: tb/sat_addsub_tb.sv
module sat_addsub_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic       opSub = 1'b0;
  logic       signedMode = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic       outValid;
  logic [7:0] result;
  logic       ovf, unf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sat_addsub u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opSub(opSub),
    .signedMode(signedMode), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .ovf(ovf), .unf(unf)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one operation at a falling edge, check it at the next falling edge.
  task automatic runOp(input bit sub, input bit sgn, input logic [7:0] a, input logic [7:0] b);
    int ai, bi, r, expRes, expOvf, expUnf, ceil, floor;
    string tag;
    inValid = 1'b1; opSub = sub; signedMode = sgn; opA = a; opB = b;
    ai = sgn ? int'($signed(a)) : int'(a);
    bi = sgn ? int'($signed(b)) : int'(b);
    r  = sub ? ai - bi : ai + bi;
    ceil  = sgn ? 127 : 255;
    floor = sgn ? -128 : 0;
    expOvf = 0; expUnf = 0;
    if (r > ceil) begin
      expRes = ceil; expOvf = 1; tag = sgn ? "R5" : "R3";
    end else if (r < floor) begin
      expRes = floor; expUnf = 1; tag = sgn ? "R6" : "R4";
    end else begin
      expRes = r; tag = sub ? "R7 R10 in-range sub" : "R7 R10 in-range add";
    end
    @(negedge clk);
    check("R2 outValid", int'(outValid), 1);
    check({tag, " result"}, int'(result), expRes & 8'hFF);
    check({tag, " ovf"}, int'(ovf), expOvf);
    check({tag, " unf"}, int'(unf), expUnf);
    check("R8 exclusive flags", int'(ovf & unf), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] holdRes;
    logic       holdOvf, holdUnf;
    repeat (3) @(negedge clk);
    check("R1 outValid", int'(outValid), 0);
    check("R1 result", int'(result), 0);
    check("R1 ovf", int'(ovf), 0);
    check("R1 unf", int'(unf), 0);
    rst = 1'b0;

    // Directed corner cases
    runOp(1'b0, 1'b0, 8'd224, 8'd64);   // R3 clamp to 255
    runOp(1'b0, 1'b0, 8'd191, 8'd64);   // R7 exactly 255
    runOp(1'b1, 1'b0, 8'd32,  8'd129);  // R4 clamp to 0
    runOp(1'b1, 1'b0, 8'd5,   8'd5);    // R7 exactly 0
    runOp(1'b1, 1'b1, 8'd156, 8'd100);  // R6 -100 - 100
    runOp(1'b0, 1'b1, 8'd100, 8'd27);   // R7 exactly 127
    runOp(1'b0, 1'b1, 8'd100, 8'd28);   // R5 128 clamps
    runOp(1'b1, 1'b1, 8'd10,  8'd5);    // R10 direction

    // Sweep: every A against a spread of B, all four modes
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int j = 0; j < 64; j++) begin
          runOp(m[0], m[1], 8'(a), 8'(j * 4 + (j % 4)));
        end
      end
    end

    // R9 / R2: idle strobe, operands and modes change, outputs hold
    runOp(1'b0, 1'b0, 8'd250, 8'd10);
    holdRes = result; holdOvf = ovf; holdUnf = unf;
    inValid = 1'b0; opSub = 1'b1; signedMode = 1'b1; opA = 8'd128; opB = 8'd1;
    @(negedge clk);
    check("R2 outValid low when idle", int'(outValid), 0);
    opSub = 1'b0; signedMode = 1'b0; opA = 8'd3; opB = 8'd4;
    @(negedge clk);
    check("R9 result held", int'(result), int'(holdRes));
    check("R9 ovf held", int'(ovf), int'(holdOvf));
    check("R9 unf held", int'(unf), int'(holdUnf));

    // R1: reset clears after activity
    rst = 1'b1;
    @(negedge clk);
    check("R1 result after reset", int'(result), 0);
    check("R1 ovf after reset", int'(ovf), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule